// File: doc/BRIEF.md
# Arbitrary Pulse Shape Synthesizer

This block turns a stream of data bits into a stream of signed amplitude codes for a bipolar line driver. The driver-side shape of a single mark is not fixed: a host writes it into a small table, one 7-bit two's complement amplitude per write. The shape is three unit intervals long, so a mark can keep a tail running for two intervals after its own. Each interval is cut into 12, 13 or 14 phases, chosen by a mode input. Writes land in interval order: every phase of the first interval, then every phase of the second, then every phase of the third.

A phase-tick strobe paces playback. The tick that opens a new interval also samples one data bit. A space contributes nothing. Marks alternate polarity, so every other mark is played as the negated shape. On every tick the output register takes a new value. That value is the sum of three terms, all read at the same phase index: the first-interval value of the current symbol, the second-interval value of the previous symbol, and the third-interval value of the symbol before that. A load-clear input restarts the write pointer and the playback sequencer and forgets the symbol history. It does not erase the table.

The design is built around two small state machines. The loader has three states: LD_UI1, LD_UI2 and LD_UI3. It moves to the next interval, wrapping LD_UI3 back to LD_UI1, on the write that fills the last phase of the current interval. The playback sequencer has two states:
- SEQ_OPEN means the next tick starts an interval and samples a symbol. A tick moves it to SEQ_BODY.
- SEQ_BODY means the next tick plays a later phase. The tick that plays the last phase moves it back to SEQ_OPEN.

Top module: `ps_synth`

## Requirements
- R1: Each write with `wr_en` stores `wr_data` at the write pointer. The pointer starts at phase 1 of interval 1 and steps through all N phases of an interval before moving to the next. After the last phase of interval 3, the next write goes to phase 1 of interval 1.
- R2: The phase count N is set by `mode`: 2'b00 gives 12, 2'b01 gives 13, and 2'b10 or 2'b11 gives 14. Every interval lasts exactly N ticks. `sym_in` is sampled only on the tick that plays phase 1 of an interval, and its value on any other tick has no effect.
- R3: A space (`sym_in`=0) contributes zero. Once three spaces are in the history, `amp_out` is 0 on every tick.
- R4: After a load-clear, the first mark is positive. If that mark follows two spaces, on its three intervals `amp_out` equals the stored table values, sign-extended and played in order.
- R5: On every tick, `amp_out` is the sum of three terms at the same phase index: the first-interval value of the current symbol, the second-interval value of the previous symbol, and the third-interval value of the symbol two intervals back.
- R6: Marks alternate polarity, and spaces do not change which polarity comes next. A negative mark contributes the two's complement negation of each stored value, after sign extension to 8 bits.
- R7: `amp_out` is 9-bit signed and never wraps. Three terms at full scale give +190: values 0x3F, 0x40 and 0x3F with marks played positive, negative, positive. The mirror pattern gives -190.
- R8: Table slots for phases at or beyond N keep whatever was written to them, but are never played while N is smaller.
- R9: `load_clr` acts at the next edge. It puts the write pointer at phase 1 of interval 1, sets the history to three spaces, makes the next mark positive, puts the sequencer in SEQ_OPEN and sets `amp_out` to 0. Table contents are kept. Reset has the same effect and also zeroes the table.
- R10: `amp_out` changes only on a clock edge where `phase_tick` or `load_clr` is high. On any other edge it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_clr | input | 1 | Restarts the write pointer, the sequencer and the history |
| mode | input | 2 | Phases per interval: 00=12, 01=13, 1x=14 |
| wr_en | input | 1 | Shape write strobe |
| wr_data | input | 7 | Shape amplitude, two's complement |
| phase_tick | input | 1 | Advances playback by one phase |
| sym_in | input | 1 | Data bit, sampled on the tick that opens an interval |
| amp_out | output | 9 | Summed amplitude code, two's complement |

## Verification
- `amp_out` is registered. A tick presented before edge k produces its value at edge k. The bench samples 2 ns after that edge and compares against a reference model that it advances in the same task.
- A shape write is visible to ticks from the following cycle onward. The bench never issues a write and a tick in the same cycle.
- `load_clr` acts at one edge. The bench samples just after that edge and checks for zero before any further tick.
- Hold behaviour is checked by idling one clock after a tick and confirming the previous value is still present.

// File: rtl/ps_pkg.sv
package ps_pkg;

    localparam int UI_CNT = 3;

    typedef enum logic [1:0] {
        LD_UI1 = 2'd0,
        LD_UI2 = 2'd1,
        LD_UI3 = 2'd2
    } ld_state_t;

    typedef enum logic {
        SEQ_OPEN = 1'b0,
        SEQ_BODY = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic mark;
        logic neg;
    } sym_t;

    function automatic logic [3:0] phases_for(input logic [1:0] m);
        logic [3:0] n;
        unique case (m)
            2'b00:   n = 4'd12;
            2'b01:   n = 4'd13;
            default: n = 4'd14;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ps_shape_store.sv
module ps_shape_store
    import ps_pkg::*;
#(
    parameter int AMP_W  = 7,
    parameter int PH_MAX = 14,
    parameter int CNT_W  = $clog2(PH_MAX + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_clr,
    input  logic                            wr_en,
    input  logic [AMP_W-1:0]                wr_data,
    input  logic [CNT_W-1:0]                n_ph,
    input  logic [CNT_W-1:0]                rd_ph,
    output logic [UI_CNT-1:0][AMP_W-1:0]    rd_val
);

    ld_state_t          st, st_nxt;
    logic [CNT_W-1:0]   wr_ph;
    logic [1:0]         ui_sel;
    logic               wr_last;
    logic [AMP_W-1:0]   tbl [UI_CNT][PH_MAX];

    assign wr_last = wr_en && (wr_ph >= n_ph - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        st <= LD_UI1;
        else if (load_clr) st <= LD_UI1;
        else               st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        ui_sel = 2'd0;
        unique case (st)
            LD_UI1: begin
                ui_sel = 2'd0;
                if (wr_last) st_nxt = LD_UI2;
            end
            LD_UI2: begin
                ui_sel = 2'd1;
                if (wr_last) st_nxt = LD_UI3;
            end
            LD_UI3: begin
                ui_sel = 2'd2;
                if (wr_last) st_nxt = LD_UI1;
            end
            default: begin
                ui_sel = 2'd0;
                st_nxt = LD_UI1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wr_ph <= '0;
        else if (load_clr) wr_ph <= '0;
        else if (wr_en)    wr_ph <= wr_last ? '0 : wr_ph + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int u = 0; u < UI_CNT; u++)
                for (int p = 0; p < PH_MAX; p++)
                    tbl[u][p] <= '0;
        end else if (wr_en && !load_clr) begin
            tbl[ui_sel][wr_ph] <= wr_data;
        end
    end

    for (genvar u = 0; u < UI_CNT; u++) begin : g_rd
        assign rd_val[u] = tbl[u][rd_ph];
    end

    // R1
    wrap_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !load_clr && st == LD_UI3 && wr_ph == n_ph - CNT_W'(1))
        |=> (st == LD_UI1 && wr_ph == '0));

    // R9
    ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_clr |=> (st == LD_UI1 && wr_ph == '0));

endmodule

// File: rtl/ps_phase_seq.sv
module ps_phase_seq
    import ps_pkg::*;
#(
    parameter int PH_MAX = 14,
    parameter int CNT_W  = $clog2(PH_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_clr,
    input  logic                     phase_tick,
    input  logic                     sym_in,
    input  logic [CNT_W-1:0]         n_ph,
    output logic [CNT_W-1:0]         rd_ph,
    output sym_t [UI_CNT-1:0]        eff_sym
);

    seq_state_t         st, st_nxt;
    logic [CNT_W-1:0]   ph_cnt, ph_nxt;
    logic               pol_neg;
    sym_t               new_sym;
    sym_t [UI_CNT-1:0]  hist;
    logic               open_tick;

    assign open_tick = phase_tick && (st == SEQ_OPEN);
    assign new_sym   = '{mark: sym_in, neg: sym_in && pol_neg};
    assign rd_ph     = ph_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        st <= SEQ_OPEN;
        else if (load_clr) st <= SEQ_OPEN;
        else               st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        ph_nxt = ph_cnt;
        unique case (st)
            SEQ_OPEN: begin
                if (phase_tick) begin
                    st_nxt = SEQ_BODY;
                    ph_nxt = CNT_W'(1);
                end
            end
            SEQ_BODY: begin
                if (phase_tick) begin
                    if (ph_cnt >= n_ph - CNT_W'(1)) begin
                        st_nxt = SEQ_OPEN;
                        ph_nxt = '0;
                    end else begin
                        ph_nxt = ph_cnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                st_nxt = SEQ_OPEN;
                ph_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ph_cnt <= '0;
        else if (load_clr) ph_cnt <= '0;
        else               ph_cnt <= ph_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_neg <= 1'b0;
            hist    <= '0;
        end else if (load_clr) begin
            pol_neg <= 1'b0;
            hist    <= '0;
        end else if (open_tick) begin
            hist <= {hist[UI_CNT-2:0], new_sym};
            if (sym_in) pol_neg <= ~pol_neg;
        end
    end

    assign eff_sym[0] = (st == SEQ_OPEN) ? new_sym : hist[0];
    for (genvar k = 1; k < UI_CNT; k++) begin : g_eff
        assign eff_sym[k] = (st == SEQ_OPEN) ? hist[k-1] : hist[k];
    end

    // R6
    ami_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_tick && !load_clr && sym_in) |=> (pol_neg != $past(pol_neg)));

    // R6
    space_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_tick && !load_clr && !sym_in) |=> $stable(pol_neg));

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_tick && !load_clr && ph_cnt < n_ph)
        |=> (ph_cnt < n_ph || n_ph != $past(n_ph)));

    // R9
    hist_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_clr |=> (!pol_neg && hist == '0 && st == SEQ_OPEN && ph_cnt == '0));

endmodule

// File: rtl/ps_mixer.sv
module ps_mixer
    import ps_pkg::*;
#(
    parameter int AMP_W = 7,
    parameter int SUM_W = AMP_W + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load_clr,
    input  logic                           tick,
    input  sym_t [UI_CNT-1:0]              eff_sym,
    input  logic [UI_CNT-1:0][AMP_W-1:0]   val,
    output logic signed [SUM_W-1:0]        amp_out
);

    localparam int EXT_W = AMP_W + 1;

    logic signed [EXT_W-1:0] term [UI_CNT];
    logic signed [SUM_W-1:0] sum;
    logic                    any_mark;

    for (genvar u = 0; u < UI_CNT; u++) begin : g_term
        logic signed [EXT_W-1:0] ext;
        assign ext = signed'({val[u][AMP_W-1], val[u]});
        always_comb begin
            if (!eff_sym[u].mark)    term[u] = '0;
            else if (eff_sym[u].neg) term[u] = -ext;
            else                     term[u] = ext;
        end
    end

    always_comb begin
        sum      = '0;
        any_mark = 1'b0;
        for (int u = 0; u < UI_CNT; u++) begin
            sum      = sum + {{(SUM_W-EXT_W){term[u][EXT_W-1]}}, term[u]};
            any_mark = any_mark | eff_sym[u].mark;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        amp_out <= '0;
        else if (load_clr) amp_out <= '0;
        else if (tick)     amp_out <= sum;
    end

    // R3
    quiet_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_clr && !any_mark) |=> (amp_out == '0));

    // R10
    amp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_clr) |=> $stable(amp_out));

    // R7
    amp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (amp_out <= SUM_W'(3 * (1 << (AMP_W - 1))) &&
                  amp_out >= -SUM_W'(3 * (1 << (AMP_W - 1)))));

endmodule

// File: rtl/ps_synth.sv
module ps_synth
    import ps_pkg::*;
#(
    parameter int AMP_W  = 7,
    parameter int PH_MAX = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_clr,
    input  logic [1:0]              mode,
    input  logic                    wr_en,
    input  logic [AMP_W-1:0]        wr_data,
    input  logic                    phase_tick,
    input  logic                    sym_in,
    output logic signed [AMP_W+1:0] amp_out
);

    localparam int CNT_W = $clog2(PH_MAX + 1);
    localparam int SUM_W = AMP_W + 2;

    logic [CNT_W-1:0]               n_ph;
    logic [CNT_W-1:0]               rd_ph;
    logic [UI_CNT-1:0][AMP_W-1:0]   rd_val;
    sym_t [UI_CNT-1:0]              eff_sym;

    assign n_ph = CNT_W'(phases_for(mode));

    ps_shape_store #(.AMP_W(AMP_W), .PH_MAX(PH_MAX), .CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_clr (load_clr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .n_ph     (n_ph),
        .rd_ph    (rd_ph),
        .rd_val   (rd_val)
    );

    ps_phase_seq #(.PH_MAX(PH_MAX), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_clr   (load_clr),
        .phase_tick (phase_tick),
        .sym_in     (sym_in),
        .n_ph       (n_ph),
        .rd_ph      (rd_ph),
        .eff_sym    (eff_sym)
    );

    ps_mixer #(.AMP_W(AMP_W), .SUM_W(SUM_W)) u_mix (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_clr (load_clr),
        .tick     (phase_tick),
        .eff_sym  (eff_sym),
        .val      (rd_val),
        .amp_out  (amp_out)
    );

    // R8
    read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_tick |-> (rd_ph < n_ph));

endmodule

// File: tb/ps_synth_test.sv
`timescale 1ns/1ps
module ps_synth_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_clr = 1'b0;
    logic [1:0]        mode = 2'b10;
    logic              wr_en = 1'b0;
    logic [6:0]        wr_data = '0;
    logic              phase_tick = 1'b0;
    logic              sym_in = 1'b0;
    logic signed [8:0] amp_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int tbl [3][14];
    int wui = 0, wph = 0, nph = 14, ph = 0, pol = 0;
    int h0 = 0, h1 = 0, h2 = 0;
    int last_exp = 0;

    ps_synth uut (
        .clk(clk), .rst_n(rst_n), .load_clr(load_clr), .mode(mode),
        .wr_en(wr_en), .wr_data(wr_data), .phase_tick(phase_tick),
        .sym_in(sym_in), .amp_out(amp_out)
    );

    always #4 clk = ~clk;

    function automatic int shp(int u, int p);
        return (tbl[u][p] >= 64) ? tbl[u][p] - 128 : tbl[u][p];
    endfunction

    function automatic int nph_of(int m);
        return (m == 0) ? 12 : (m == 1) ? 13 : 14;
    endfunction

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        @(negedge clk);
        load_clr = 1'b1;
        @(posedge clk);
        #2;
        load_clr = 1'b0;
        wui = 0; wph = 0; pol = 0; h0 = 0; h1 = 0; h2 = 0; ph = 0;
        last_exp = 0;
    endtask

    task automatic wr(int v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 7'(v);
        @(posedge clk);
        #2;
        wr_en = 1'b0;
        tbl[wui][wph] = v;
        if (wph == nph - 1) begin
            wph = 0;
            wui = (wui == 2) ? 0 : wui + 1;
        end else begin
            wph++;
        end
    endtask

    task automatic set_mode(int m);
        @(negedge clk);
        mode = 2'(m);
        nph = nph_of(m);
    endtask

    task automatic tick(bit b, string tag);
        int s;
        @(negedge clk);
        phase_tick = 1'b1;
        sym_in = (ph == 0) ? b : 1'($urandom_range(0, 1));
        if (ph == 0) begin
            s = b ? (pol ? -1 : 1) : 0;
            if (b) pol = 1 - pol;
            h2 = h1; h1 = h0; h0 = s;
        end
        last_exp = h0 * shp(0, ph) + h1 * shp(1, ph) + h2 * shp(2, ph);
        @(posedge clk);
        #2;
        phase_tick = 1'b0;
        chk(tag, int'(amp_out), last_exp);
        ph = (ph == nph - 1) ? 0 : ph + 1;
    endtask

    task automatic hold_chk();
        @(negedge clk);
        @(posedge clk);
        #2;
        chk("R10 hold", int'(amp_out), last_exp);
    endtask

    task automatic interval(bit b, string tag);
        for (int p = 0; p < nph; p++) tick(b, tag);
    endtask

    task automatic load_rand(int m);
        set_mode(m);
        clr();
        for (int i = 0; i < 3 * nph; i++) wr($urandom_range(0, 127));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int u = 0; u < 3; u++)
            for (int p = 0; p < 14; p++) tbl[u][p] = 0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        chk("R9 reset amp", int'(amp_out), 0);

        // R4: lone mark after clear, 14 phases
        load_rand(2);
        for (int u = 0; u < 3; u++)
            for (int p = 0; p < nph; p++) begin
                tick(u == 0, "R4");
                chk("R4 raw", int'(amp_out), shp(u, p));
            end

        // R3: spaces give zero
        interval(1'b0, "R3");
        interval(1'b0, "R3");

        // R6: back-to-back marks alternate
        clr();
        for (int i = 0; i < 4; i++) interval(1'b1, "R6");
        hold_chk();

        // R5 / R2: random bits, off-phase sym_in noise
        for (int i = 0; i < 40; i++) begin
            interval(1'($urandom_range(0, 1)), "R5");
            if (i % 8 == 0) hold_chk();
        end

        // R7: full-scale sums
        set_mode(0);
        clr();
        for (int i = 0; i < 12; i++) wr(7'h3F);
        for (int i = 0; i < 12; i++) wr(7'h40);
        for (int i = 0; i < 12; i++) wr(7'h3F);
        interval(1'b1, "R7");
        interval(1'b1, "R7");
        tick(1'b1, "R7");
        chk("R7 max", int'(amp_out), 190);
        for (int p = 1; p < 12; p++) tick(1'b1, "R7");
        tick(1'b1, "R7");
        chk("R7 min", int'(amp_out), -190);
        for (int p = 1; p < 12; p++) tick(1'b1, "R7");

        // R1: pointer wrap past 3N writes
        clr();
        for (int i = 0; i < 38; i++) wr($urandom_range(0, 127));
        clr();
        interval(1'b1, "R1");
        interval(1'b0, "R1");
        interval(1'b0, "R1");
        // R1/R9: partial load then clear restarts at UI1 phase 1
        for (int i = 0; i < 5; i++) wr($urandom_range(0, 127));
        clr();
        wr(7'h21);
        tick(1'b1, "R1");
        chk("R1 first slot", int'(amp_out), 33);

        // R8: longer table played with fewer phases
        load_rand(2);
        set_mode(1);
        clr();
        for (int i = 0; i < 12; i++) interval(1'($urandom_range(0, 1)), "R8");
        set_mode(0);
        clr();
        for (int i = 0; i < 12; i++) interval(1'($urandom_range(0, 1)), "R8");

        // R9: mid-stream clear resets history and polarity
        set_mode(3);
        nph = 14;
        clr();
        interval(1'b1, "R9");
        tick(1'b1, "R9");
        clr();
        chk("R9 clr amp", int'(amp_out), 0);
        interval(1'b1, "R9");
        interval(1'b0, "R9");
        interval(1'b0, "R9");
        interval(1'b0, "R9");
        chk("R9 quiet", int'(amp_out), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule